// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block sits on a processor's local bus and routes each access to one of five targets: boot ROM, SSRAM, SDRAM, the core-module register space or the external system bus. If an access has no target that exists in the current setup, the block signals an abort instead. It samples a request together with its address, write flag and write data. One cycle later it raises exactly one target select line, or the abort line. For a read of the control register, it also returns read data in that same cycle.

The lowest 256 KB of the address space is the boot window. Two inputs decide where it goes: a remap bit that software writes, and an active-low input that reports whether a motherboard is attached. After reset the window points at boot ROM, provided a motherboard is present. Software sets the remap bit to move SSRAM into that window. With no motherboard attached, the window always holds SSRAM, and the upper system-bus range aborts.

Response sequencing uses a two-state machine. `ST_IDLE` means no response is due in the current cycle. `ST_RESP` means the response for the request sampled at the last edge is being presented.

Its transitions are:
- `GO_RESP`: a request is sampled, from either state.
- `GO_IDLE`: no request is sampled, from either state.

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is active, and in the first cycle after it, `tgt_sel`, `abort` and `rdata` are all zero. The remap bit resets to 0.
- R2: A request in 0x00000000..0x0003FFFF, with `mb_present_n`=0 and remap=0, selects boot ROM (`tgt_sel` bit 0).
- R3: A request in 0x00000000..0x0003FFFF, with `mb_present_n`=0 and remap=1, selects SSRAM (`tgt_sel` bit 1).
- R4: A request in 0x00000000..0x0003FFFF with `mb_present_n`=1 selects SSRAM (`tgt_sel` bit 1), whatever the remap bit holds.
- R5: A request in 0x00040000..0x0FFFFFFF selects SDRAM (`tgt_sel` bit 2), whatever remap and presence hold.
- R6: A request in 0x10000000..0x10FFFFFF selects register space (`tgt_sel` bit 3).
- R7: A request in 0x11000000..0xFFFFFFFF selects the system bus (`tgt_sel` bit 4) when `mb_present_n`=0. It raises `abort` instead when `mb_present_n`=1.
- R8: The control register is at 0x1000000C, and only its bit 2 (remap) is implemented. A write to that address loads `wdata` bit 2 into remap and ignores every other bit. Writes to any other address leave remap unchanged. A read of that address returns remap in `rdata` bit 2, with all other bits 0. Every other response carries `rdata` = 0.
- R9: A write to the remap bit applies from the next request onward. A boot-window request in the cycle right after the write is already decoded with the new value.
- R10: Each sampled request gets its response in the following cycle, with exactly one of the five select bits or `abort` high. A cycle with no sampled request leaves every output low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, sampled each edge |
| addr | input | 32 | Byte address of the access |
| we | input | 1 | 1 = write, 0 = read |
| wdata | input | 32 | Write data |
| mb_present_n | input | 1 | 0 = motherboard attached |
| tgt_sel | output | 5 | One-hot target: 0 ROM, 1 SSRAM, 2 SDRAM, 3 registers, 4 system bus |
| abort | output | 1 | Access has no target |
| rdata | output | 32 | Control register read data |

## Verification
Every result comes from a single register stage. The select lines, abort and read data for a request sampled at one rising edge are valid from that edge until the next one. A remap write lands at the same edge, so the request sampled at the following edge already sees it. The bench reference model computes the expected response at each rising edge from the inputs it drove half a cycle earlier, and queues that result. At the next falling edge it removes the result from the queue and compares it against the outputs. This holds the comparison to exactly one cycle of latency, with no slack in either direction.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned N_TGT    = 5;

    // Region limits (inclusive upper bounds)
    localparam logic [ADDR_W-1:0] BOOT_LAST  = 32'h0003_FFFF;
    localparam logic [ADDR_W-1:0] SDRAM_LAST = 32'h0FFF_FFFF;
    localparam logic [ADDR_W-1:0] REGS_LAST  = 32'h10FF_FFFF;
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = 32'h1000_000C;
    localparam int unsigned       REMAP_BIT  = 2;

    // Target codes; the index of each select bit matches its code
    typedef enum logic [2:0] {
        TGT_ROM    = 3'd0,
        TGT_SRAM   = 3'd1,
        TGT_SDRAM  = 3'd2,
        TGT_REGS   = 3'd3,
        TGT_SYSBUS = 3'd4,
        TGT_ABORT  = 3'd5
    } target_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;

endpackage

// File: rtl/boot_remap_region.sv
// Combinational region decode of one address.
module boot_remap_region
    import boot_remap_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned NT = N_TGT
) (
    input  logic [AW-1:0] addr,
    input  logic          mb_present_n,
    input  logic          remap,
    output target_e       target,
    output logic [NT-1:0] sel_vec,
    output logic          is_abort
);

    logic in_boot;
    logic in_sdram;
    logic in_regs;

    assign in_boot  = (addr <= BOOT_LAST);
    assign in_sdram = !in_boot && (addr <= SDRAM_LAST);
    assign in_regs  = (addr > SDRAM_LAST) && (addr <= REGS_LAST);

    always_comb begin
        if (in_boot) begin
            // The remap bit steers the window only with a board attached
            if (!mb_present_n && !remap) target = TGT_ROM;
            else                         target = TGT_SRAM;
        end else if (in_sdram) begin
            target = TGT_SDRAM;
        end else if (in_regs) begin
            target = TGT_REGS;
        end else if (!mb_present_n) begin
            target = TGT_SYSBUS;
        end else begin
            target = TGT_ABORT;
        end
    end

    for (genvar g = 0; g < NT; g++) begin : g_sel
        assign sel_vec[g] = (target == target_e'(g));
    end

    assign is_abort = (target == TGT_ABORT);

endmodule

// File: rtl/boot_remap_ctrl.sv
// Control register holding the remap bit.
module boot_remap_ctrl
    import boot_remap_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned RB = REMAP_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          remap_q,
    output logic [DW-1:0] view
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     remap_q <= 1'b0;
        else if (wr_en) remap_q <= wdata[RB];
    end

    always_comb begin
        view     = '0;
        view[RB] = remap_q;
    end

endmodule

// File: rtl/boot_remap_resp.sv
// Response sequencer: one registered response per sampled request.
module boot_remap_resp
    import boot_remap_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned NT = N_TGT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [NT-1:0] sel_in,
    input  logic          abort_in,
    input  logic          rd_ctrl,
    input  logic [DW-1:0] ctrl_view,
    output resp_state_e   state,
    output logic [NT-1:0] tgt_sel,
    output logic          abort,
    output logic [DW-1:0] rdata
);

    resp_state_e state_nx;

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = req ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output register, loaded for the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_sel <= '0;
            abort   <= 1'b0;
            rdata   <= '0;
        end else begin
            unique case (state_nx)
                ST_RESP: begin
                    tgt_sel <= sel_in;
                    abort   <= abort_in;
                    rdata   <= rd_ctrl ? ctrl_view : '0;
                end
                default: begin
                    tgt_sel <= '0;
                    abort   <= 1'b0;
                    rdata   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
    import boot_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mb_present_n,
    output logic [N_TGT-1:0]  tgt_sel,
    output logic              abort,
    output logic [DATA_W-1:0] rdata
);

    logic              remap_q;
    logic [DATA_W-1:0] ctrl_view;
    target_e           target;
    logic [N_TGT-1:0]  sel_vec;
    logic              is_abort;
    logic              hit_ctrl;
    resp_state_e       state;

    assign hit_ctrl = req && (addr == CTRL_ADDR);

    boot_remap_region #(.AW(ADDR_W), .NT(N_TGT)) u_region (
        .addr         (addr),
        .mb_present_n (mb_present_n),
        .remap        (remap_q),
        .target       (target),
        .sel_vec      (sel_vec),
        .is_abort     (is_abort)
    );

    boot_remap_ctrl #(.DW(DATA_W), .RB(REMAP_BIT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hit_ctrl && we),
        .wdata   (wdata),
        .remap_q (remap_q),
        .view    (ctrl_view)
    );

    boot_remap_resp #(.DW(DATA_W), .NT(N_TGT)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .sel_in    (sel_vec),
        .abort_in  (is_abort),
        .rd_ctrl   (hit_ctrl && !we),
        .ctrl_view (ctrl_view),
        .state     (state),
        .tgt_sel   (tgt_sel),
        .abort     (abort),
        .rdata     (rdata)
    );

endmodule

// File: rtl/boot_remap_decoder_chk.sv
module boot_remap_decoder_chk
    import boot_remap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic              mb_present_n,
    input logic              remap_q,
    input logic [N_TGT-1:0]  tgt_sel,
    input logic              abort,
    input logic [DATA_W-1:0] rdata
);

    logic boot_hit;
    logic sdram_hit;
    logic upper_hit;
    assign boot_hit  = addr <= BOOT_LAST;
    assign sdram_hit = (addr > BOOT_LAST) && (addr <= SDRAM_LAST);
    assign upper_hit = addr > REGS_LAST;

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ($countones({tgt_sel, abort}) == 1)); // R10
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ({tgt_sel, abort} == '0)); // R10
    AST_ROM_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && boot_hit && !mb_present_n && !remap_q) |=> tgt_sel[0]); // R2
    AST_SRAM_REMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && boot_hit && !mb_present_n && remap_q) |=> tgt_sel[1]); // R3
    AST_SRAM_NO_BOARD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && boot_hit && mb_present_n) |=> tgt_sel[1]); // R4
    AST_SDRAM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && sdram_hit) |=> tgt_sel[2]); // R5
    AST_ABORT_NO_BOARD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && upper_hit && mb_present_n) |=> abort); // R7
    AST_RDATA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~(32'h1 << REMAP_BIT)) == '0); // R8
    AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we && addr == CTRL_ADDR) |=> $stable(remap_q)); // R8

endmodule

bind boot_remap_decoder boot_remap_decoder_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .addr         (addr),
    .we           (we),
    .mb_present_n (mb_present_n),
    .remap_q      (remap_q),
    .tgt_sel      (tgt_sel),
    .abort        (abort),
    .rdata        (rdata)
);

// File: tb/boot_remap_decoder_tb_top.sv
`timescale 1ns/1ps
module boot_remap_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        mb_present_n = 1'b0;
    logic [4:0]  tgt_sel;
    logic        abort;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    boot_remap_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we(we),
        .wdata(wdata), .mb_present_n(mb_present_n),
        .tgt_sel(tgt_sel), .abort(abort), .rdata(rdata)
    );

    // Reference model: expected {sel, abort, rdata} queued at each rising edge
    logic [37:0] exp_q[$];
    string       tag_q[$];
    int          m_remap = 0;
    bit          last_wr_ctrl = 1'b0;

    always @(posedge clk) begin
        logic [4:0]  e_sel;
        logic        e_ab;
        logic [31:0] e_rd;
        string       t;
        e_sel = '0; e_ab = 1'b0; e_rd = '0; t = "R10";
        if (!rst_n) begin
            m_remap = 0;
            last_wr_ctrl = 1'b0;
            t = "R1";
        end else if (req) begin
            if (addr < 32'h0004_0000) begin
                if (mb_present_n == 1'b1)  begin e_sel = 5'b00010; t = "R4"; end
                else if (m_remap == 0)     begin e_sel = 5'b00001; t = "R2"; end
                else                       begin e_sel = 5'b00010; t = "R3"; end
                if (last_wr_ctrl) t = "R9";
            end else if (addr < 32'h1000_0000) begin
                e_sel = 5'b00100; t = "R5";
            end else if (addr < 32'h1100_0000) begin
                e_sel = 5'b01000; t = "R6";
                if (addr == 32'h1000_000C) begin
                    t = "R8";
                    if (!we) e_rd = (m_remap != 0) ? 32'h4 : 32'h0;
                end
            end else if (mb_present_n == 1'b0) begin
                e_sel = 5'b10000; t = "R7";
            end else begin
                e_ab = 1'b1; t = "R7";
            end
            last_wr_ctrl = we && (addr == 32'h1000_000C);
            if (last_wr_ctrl) m_remap = (wdata & 32'h4) != 0 ? 1 : 0;
        end else begin
            last_wr_ctrl = 1'b0;
        end
        exp_q.push_back({e_sel, e_ab, e_rd});
        tag_q.push_back(t);
    end

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [37:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({tgt_sel, abort, rdata} !== e) begin
                errors++;
                $display("FAIL %s: actual sel=%b abort=%b rdata=%h expected sel=%b abort=%b rdata=%h",
                         t, tgt_sel, abort, rdata, e[37:33], e[32], e[31:0]);
            end
        end
    end

    task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; addr = a; we = w; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req = 1'b0; we = 1'b0;
        end
    endtask

    task automatic board(input logic pn);
        @(negedge clk);
        req = 1'b0; mb_present_n = pn;
    endtask

    initial begin
        // R1: outputs zero in reset and just after it
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        access(32'h1000_000C, 1'b0, '0);      // R1 remap reads back 0
        // R2 boot ROM with board and remap clear
        access(32'h0000_0000, 1'b0, '0);
        access(32'h0003_FFFC, 1'b1, '0);
        // R5, R6, R7 region edges
        access(32'h0004_0000, 1'b0, '0);
        access(32'h0FFF_FFFF, 1'b1, '0);
        access(32'h1000_0000, 1'b0, '0);
        access(32'h10FF_FFFF, 1'b0, '0);
        access(32'h1100_0000, 1'b0, '0);
        access(32'hFFFF_FFFF, 1'b1, '0);
        idle(1);
        // R8 write sets only remap; R9 next request already sees it
        access(32'h1000_000C, 1'b1, 32'hFFFF_FFFF);
        access(32'h0000_1000, 1'b0, '0);
        access(32'h1000_000C, 1'b0, '0);
        // R8 writes elsewhere leave remap alone
        access(32'h1000_0008, 1'b1, 32'h0000_0000);
        access(32'h0000_0000, 1'b0, '0);      // R3
        access(32'h1000_000C, 1'b1, 32'hFFFF_FFFB);
        access(32'h0000_0004, 1'b0, '0);      // R9 back to ROM
        access(32'h1000_000C, 1'b0, '0);
        // R4, R7 without board, both remap values
        board(1'b1);
        access(32'h0000_0000, 1'b0, '0);
        access(32'h1100_0000, 1'b0, '0);
        access(32'h8000_0000, 1'b1, '0);
        access(32'h1000_000C, 1'b1, 32'h0000_0004);
        access(32'h0003_FFFF, 1'b0, '0);
        access(32'h0400_0000, 1'b0, '0);      // R5 unaffected
        board(1'b0);
        access(32'h0000_0000, 1'b0, '0);      // R3
        // Mixed sweep with idle gaps (R10)
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a;
            a = 32'(k) * 32'h0271_3A5F + 32'h0001_0000;
            if (k % 17 == 0) a = 32'h1000_000C;
            if (k % 23 == 0) board(~mb_present_n);
            if (k % 5 == 0) idle(1);
            access(a, (k % 3) == 0, 32'(k) << 1);
        end
        idle(3);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual hung expected finished");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule